// File: doc/BRIEF.md
# Dual-Function Interrupt Router

This block steers the interrupt requests of a two-function card-socket controller onto seven multifunction output terminals. One routing register, shared by both functions, holds a 4-bit selector per terminal. A selector can leave its terminal unused, or drive it with the first or second PCI interrupt line, or with one of the legacy ISA-style IRQ levels 3 to 15 that the socket logic raises.

A tie bit in the system control register merges the interrupts of both functions onto the first PCI interrupt line. The same bit changes the read-only interrupt pin value that each function reports in its configuration space. Software writes the registers through a simple dword port tagged with a function number. Both functions reach the same physical registers, so one write through either function sets up every terminal.

All outputs are active-high levels that follow the request inputs without any latching. They suit the level inputs of a legacy programmable interrupt controller.

Top module: `irq_route`

## Requirements
- R1: While reset is held and after reset, every terminal is low, the tie bit is clear and the routing register is zero. The interrupt pin value is 01h for function 0 and 02h for function 1.
- R2: A write with `reg_we` high to the dword at byte offset 8Ch sets the routing register from `reg_wdata[27:0]`, whichever function `reg_func` names. Terminal i takes its selector from bits [4i+3:4i]. The new routing shows on the terminals from the clock edge that samples the write onward.
- R3: Selector code 0 drives its terminal low. Code 1 drives the INTA line, code 2 the INTB line, and code k from 3 to 15 drives `isa_irq[k]`.
- R4: With the tie bit clear, the INTA line equals `int_req[0]` (function 0) and the INTB line equals `int_req[1]` (function 1).
- R5: The tie bit is bit 29 of the dword at byte offset 80h, written by either function. When it is set, the INTA line is the OR of both requests and the INTB line is low.
- R6: `pin_data` gives the interrupt pin value of the function named by `reg_func`: 01h/02h with the tie bit clear, 01h for both functions with it set.
- R7: A write to any other dword, or a cycle with `reg_we` low, changes neither the routing register nor the tie bit. The terminals keep following the previous routing.
- R8: Terminals are combinational levels. A request that drops is seen low on its terminal in the same cycle, with no held state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_func | input | 1 | Function number of the access and of the pin read |
| reg_addr | input | 8 | Configuration byte address, decoded by dword |
| reg_wdata | input | 32 | Register write data |
| int_req | input | 2 | Interrupt request of function 0 (bit 0) and function 1 (bit 1) |
| isa_irq | input | 16 | Legacy IRQ levels; bits 3 to 15 can be routed |
| pin_data | output | 8 | Interrupt pin value of the selected function |
| mfunc | output | 7 | Multifunction terminals, active high |

## Verification
The assertions take the write port to be a full-dword access with stable address and data around the sampling edge. They also take any bit pattern on the request and IRQ inputs to be legal, because the routing logic has no protocol of its own. The random stimulus changes every input only at the falling clock edge. It picks write addresses from the two register dwords, a byte address inside the routing dword and an unrelated dword, and it draws request and IRQ patterns from the whole input space.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int          SEL_W      = 4;
   localparam int          TERM_N     = 7;
   localparam logic [7:0]  OFS_SYSCTL = 8'h80;
   localparam logic [7:0]  OFS_ROUTE  = 8'h8C;
   localparam int          TIE_POS    = 29;
   localparam logic [7:0]  PIN_LINE_A = 8'h01;
   localparam logic [7:0]  PIN_LINE_B = 8'h02;

   typedef enum logic [SEL_W-1:0] {
      SEL_OFF   = 4'd0,
      SEL_LINEA = 4'd1,
      SEL_LINEB = 4'd2
   } sel_code_e;
endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs #(
   parameter int         TERM_N   = irq_route_pkg::TERM_N,
   parameter int         SEL_W    = irq_route_pkg::SEL_W,
   parameter logic [7:0] ROUTE_OF = irq_route_pkg::OFS_ROUTE,
   parameter logic [7:0] CTL_OF   = irq_route_pkg::OFS_SYSCTL,
   parameter int         TIE_POS  = irq_route_pkg::TIE_POS,
   localparam int        ROUTE_W  = TERM_N * SEL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [7:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [ROUTE_W-1:0] route_q,
   output logic               tie_q
);
   if (ROUTE_W > 32) begin : g_bad_route_w
      $error("routing fields do not fit a dword");
   end
   if (TIE_POS > 31 || TIE_POS < 0) begin : g_bad_tie_pos
      $error("tie bit position outside a dword");
   end

   logic hit_route, hit_ctl;
   logic unused_wdata;

   assign hit_route    = reg_addr[7:2] == ROUTE_OF[7:2];
   assign hit_ctl      = reg_addr[7:2] == CTL_OF[7:2];
   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
         tie_q   <= 1'b0;
      end else if (reg_we) begin
         if (hit_route) route_q <= reg_wdata[ROUTE_W-1:0];
         if (hit_ctl)   tie_q   <= reg_wdata[TIE_POS];
      end
   end

   // R2
   route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && hit_route) |=> route_q == $past(reg_wdata[ROUTE_W-1:0]));
   // R7
   route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && hit_route) |=> $stable(route_q));
   // R5
   tie_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && hit_ctl) |=> tie_q == $past(reg_wdata[TIE_POS]));
   // R7
   tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && hit_ctl) |=> $stable(tie_q));
endmodule

// File: rtl/irq_route_lines.sv
module irq_route_lines #(
   parameter logic [7:0] PIN_A = irq_route_pkg::PIN_LINE_A,
   parameter logic [7:0] PIN_B = irq_route_pkg::PIN_LINE_B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tie,
   input  logic [1:0] int_req,
   input  logic       func,
   output logic       line_a,
   output logic       line_b,
   output logic [7:0] pin_val
);
   if (PIN_A == PIN_B) begin : g_bad_pins
      $error("pin values of the two lines must differ");
   end

   always_comb begin
      if (tie) begin
         line_a  = int_req[0] | int_req[1];
         line_b  = 1'b0;
         pin_val = PIN_A;
      end else begin
         line_a  = int_req[0];
         line_b  = int_req[1];
         pin_val = func ? PIN_B : PIN_A;
      end
   end

   // R5
   tied_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tie && int_req != 2'b00) |-> line_a);
   // R4
   untied_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tie && int_req[0] != int_req[1]) |-> line_a != line_b);
endmodule

// File: rtl/irq_route_mux.sv
module irq_route_mux #(
   parameter int SEL_W = irq_route_pkg::SEL_W,
   localparam int SRC_N = 1 << SEL_W
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             line_a,
   input  logic             line_b,
   input  logic [SRC_N-1:0] isa_irq,
   output logic             term
);
   if (SRC_N < 4) begin : g_bad_sel_w
      $error("selector too narrow for the fixed codes");
   end

   logic [SRC_N-1:0] src;

   always_comb begin
      src    = isa_irq;
      src[0] = 1'b0;
      src[1] = line_a;
      src[2] = line_b;
      term   = src[sel];
   end

   // R3
   off_low_chk: assert final (sel != irq_route_pkg::SEL_OFF || !term);
endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int         TERM_N   = irq_route_pkg::TERM_N,
   parameter int         SEL_W    = irq_route_pkg::SEL_W,
   parameter logic [7:0] ROUTE_OF = irq_route_pkg::OFS_ROUTE,
   parameter logic [7:0] CTL_OF   = irq_route_pkg::OFS_SYSCTL,
   parameter int         TIE_POS  = irq_route_pkg::TIE_POS,
   localparam int        ROUTE_W  = TERM_N * SEL_W,
   localparam int        SRC_N    = 1 << SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_func,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic [1:0]        int_req,
   input  logic [SRC_N-1:0]  isa_irq,
   output logic [7:0]        pin_data,
   output logic [TERM_N-1:0] mfunc
);
   if (TERM_N < 2) begin : g_bad_term_n
      $error("two PCI lines need at least two terminals");
   end
   if (ROUTE_OF[7:2] == CTL_OF[7:2]) begin : g_bad_ofs
      $error("routing and control registers share a dword");
   end

   logic [ROUTE_W-1:0] route;
   logic               tie;
   logic               line_a, line_b;

   irq_route_regs #(
      .TERM_N(TERM_N), .SEL_W(SEL_W), .ROUTE_OF(ROUTE_OF),
      .CTL_OF(CTL_OF), .TIE_POS(TIE_POS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .route_q(route), .tie_q(tie)
   );

   irq_route_lines u_lines (
      .clk(clk), .rst_n(rst_n), .tie(tie), .int_req(int_req),
      .func(reg_func), .line_a(line_a), .line_b(line_b), .pin_val(pin_data)
   );

   for (genvar t = 0; t < TERM_N; t++) begin : g_term
      irq_route_mux #(.SEL_W(SEL_W)) u_mux (
         .sel(route[t*SEL_W +: SEL_W]), .line_a(line_a), .line_b(line_b),
         .isa_irq(isa_irq), .term(mfunc[t])
      );

      // R5
      tied_lineb_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tie && route[t*SEL_W +: SEL_W] == irq_route_pkg::SEL_LINEB) |-> !mfunc[t]);
   end

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int_req == '0 && isa_irq == '0) |-> mfunc == '0);
   // R6
   tied_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tie |-> pin_data == irq_route_pkg::PIN_LINE_A);
endmodule

// File: tb/irq_route_test.sv
module irq_route_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_func = 1'b0;
   logic [7:0]  reg_addr = 8'h00;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  int_req = '0;
   logic [15:0] isa_irq = '0;
   logic [7:0]  pin_data;
   logic [6:0]  mfunc;

   int vectors = 0;
   int miscompares = 0;
   logic [27:0] m_route = '0;
   logic        m_tie = 1'b0;

   irq_route uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_func(reg_func),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .int_req(int_req),
      .isa_irq(isa_irq), .pin_data(pin_data), .mfunc(mfunc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [6:0] exp_term(logic [27:0] r, logic t,
                                           logic [1:0] q, logic [15:0] s);
      logic a, b;
      logic [6:0] o;
      a = t ? (q[0] | q[1]) : q[0];
      b = t ? 1'b0 : q[1];
      for (int i = 0; i < 7; i++) begin
         case (r[i*4 +: 4])
            4'd0:    o[i] = 1'b0;
            4'd1:    o[i] = a;
            4'd2:    o[i] = b;
            default: o[i] = s[r[i*4 +: 4]];
         endcase
      end
      return o;
   endfunction

   function automatic logic [7:0] exp_pin(logic t, logic f);
      return (t || !f) ? 8'h01 : 8'h02;
   endfunction

   task automatic step(input logic we, input logic f, input logic [7:0] a,
                       input logic [31:0] d, input logic [1:0] q,
                       input logic [15:0] s, input string tag);
      logic [6:0] em;
      logic [7:0] ep;
      @(negedge clk);
      reg_we = we; reg_func = f; reg_addr = a; reg_wdata = d;
      int_req = q; isa_irq = s;
      #1;
      em = rst_n ? exp_term(m_route, m_tie, q, s) : 7'h00;
      ep = rst_n ? exp_pin(m_tie, f) : exp_pin(1'b0, f);
      vectors++;
      if (mfunc !== em || pin_data !== ep) begin
         miscompares++;
         $display("FAIL %s: mfunc=%h pin=%h expected mfunc=%h pin=%h",
                  tag, mfunc, pin_data, em, ep);
      end
      @(posedge clk);
      if (rst_n && we) begin
         if (a[7:2] == 6'h23) m_route = d[27:0];
         if (a[7:2] == 6'h20) m_tie = d[29];
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      miscompares++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [7:0] addrs [4];
      addrs[0] = 8'h80; addrs[1] = 8'h8C; addrs[2] = 8'h84; addrs[3] = 8'h8D;
      void'($urandom(32'd1520));

      // R1: during reset, even with sources and writes active
      step(1'b1, 1'b0, 8'h8C, 32'h0111_1111, 2'b11, 16'hFFFF, "R1 in reset f0");
      step(1'b0, 1'b1, 8'h00, 32'h0, 2'b11, 16'hFFFF, "R1 in reset f1");
      @(negedge clk); rst_n = 1'b1;
      step(1'b0, 1'b0, 8'h00, 32'h0, 2'b11, 16'hFFFF, "R1 after reset f0");
      step(1'b0, 1'b1, 8'h00, 32'h0, 2'b11, 16'hFFFF, "R1 after reset f1");

      // R2: write through function 1, visible next vector
      step(1'b1, 1'b1, 8'h8C, 32'hF490_F321, 2'b01, 16'h8218, "R2 write cycle");
      step(1'b0, 1'b0, 8'h00, 32'h0, 2'b01, 16'h8218, "R2 routed f1 write");
      // R3: each code class
      step(1'b0, 1'b0, 8'h00, 32'h0, 2'b10, 16'h0000, "R3 INTB code");
      step(1'b0, 1'b0, 8'h00, 32'h0, 2'b00, 16'h0210, "R3 ISA codes");
      // R4: separate lines
      step(1'b0, 1'b0, 8'h00, 32'h0, 2'b11, 16'h0000, "R4 both requests");
      // R5: tie through function 0
      step(1'b1, 1'b0, 8'h80, 32'h2000_0000, 2'b10, 16'h0000, "R5 write cycle");
      step(1'b0, 1'b0, 8'h00, 32'h0, 2'b10, 16'h0000, "R5 tied f1 request");
      // R6: pin values tied
      step(1'b0, 1'b1, 8'h00, 32'h0, 2'b00, 16'h0000, "R6 tied pin f1");
      // R7: ignored writes
      step(1'b1, 1'b1, 8'h84, 32'hFFFF_FFFF, 2'b11, 16'hFFFF, "R7 other dword");
      step(1'b0, 1'b0, 8'h8C, 32'h0000_0000, 2'b11, 16'hFFFF, "R7 strobe low");
      step(1'b0, 1'b1, 8'h00, 32'h0, 2'b01, 16'h8000, "R7 routing kept");
      // R8: drop a request
      step(1'b0, 1'b0, 8'h00, 32'h0, 2'b00, 16'h0000, "R8 request dropped");

      // R3 random mix
      for (int n = 0; n < 3000; n++) begin
         logic we;
         we = ($urandom_range(0, 3) == 0);
         step(we, 1'($urandom), addrs[$urandom_range(0, 3)], $urandom,
              2'($urandom), 16'($urandom), "R3 random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule